// File: doc/BRIEF.md
# Shared Resource Semaphore

This block arbitrates ownership of five shared resources (control registers, two PHY management paths, non-volatile memory and flash) between a host software agent, an embedded firmware agent and an internal flash engine. Software reaches the block through a plain register read/write port. Firmware uses a one-cycle claim/release port. The flash engine drives a single busy input.

Software owns two nested locks before it may change its ownership bits. The first is an inter-driver lock that is acquired by reading it. The second is a register lock, held in the ownership register, that is acquired by reading that register while the first lock is held. Firmware requests are judged in one cycle against the current state, so firmware needs no lock. A firmware request is refused while software holds or is taking the register lock. Read data is combinational and shows the state before any side effect of the read. Every port is control-style, and no port applies back-pressure: each firmware request completes in exactly one cycle.

Top module: `resource_semaphore`

## Requirements
- R1: After reset both locks are free and every ownership bit is 0. Reads of either register return 0, and `fw_done` and `fw_granted` are 0.
- R2: The lock register is at address 0, with the lock in bit 0. A read while the lock is 0 returns 0 and sets it. A read while it is 1 returns 1 and leaves it set. Writing 0 to bit 0 frees it.
- R3: The ownership register is at address 1, with the register lock in bit 31. A read while the inter-driver lock is held and the register lock is free returns bit 31 = 0 and sets the register lock. Reads at other times have no effect.
- R4: A write to address 1 is ignored unless software holds both locks.
- R5: A write to address 1 made while both locks are held replaces the software field (bits 4:0, one bit each for CSR, PHY0, PHY1, NVM, flash). The write is accepted even when the matching firmware bit is set, and it never changes firmware bits.
- R6: A write to address 1 with bit 31 = 0 made while both locks are held frees the register lock.
- R7: A firmware claim (op 0) with mask m is granted only when none of the software or firmware bits in m is set and the register lock is free. A granted claim sets the firmware bits at the mask shifted left by 5 (bits 9:5).
- R8: A claim that includes NVM (mask bit 3) is refused while `flash_busy` is 1. The busy level reads back at bit 10 of address 1.
- R9: A firmware release (op 1) is always granted. It clears only the firmware bits in its mask and leaves software bits unchanged.
- R10: When a software read takes the register lock in the same cycle as a firmware claim, the read wins and the claim is refused.
- R11: `fw_done` is 1 for exactly one cycle, the cycle after each `fw_valid`. `fw_granted` reports the result in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rd_en | input | 1 | Software read strobe (carries the read side effects) |
| sw_wr_en | input | 1 | Software write strobe |
| sw_addr | input | 1 | 0 = lock register, 1 = ownership register |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Combinational read data for sw_addr |
| fw_valid | input | 1 | Firmware request strobe |
| fw_op | input | 1 | 0 = claim, 1 = release |
| fw_mask | input | 5 | Resource mask, in the same order as the software field |
| fw_done | output | 1 | Request completed (one cycle after fw_valid) |
| fw_granted | output | 1 | Result of the completed request |
| flash_busy | input | 1 | Flash engine currently using NVM |

## Verification
The checker enforces the following on every cycle:
- each request gets its one-cycle completion, with no completion that was not requested;
- a busy flash engine or an already-held mask bit always refuses a claim;
- releases always succeed;
- the software field never moves without a fully locked write;
- a lock-taking read beats a simultaneous claim;
- a lock-register read always leaves the lock set.

Only the bench's scenarios show certain effects, because they need a sequence of steps. These are the read-to-set return values, the forced software write over a firmware-held bit, the release of the register lock by a write, the exact register images and the clearing done by reset.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic {
    FW_CLAIM   = 1'b0,
    FW_RELEASE = 1'b1
  } fw_op_e;

  typedef enum logic {
    ADDR_LOCK = 1'b0,
    ADDR_OWN  = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/srs_lock_unit.sv
module srs_lock_unit #(
  parameter int DATA_W    = 32,
  parameter int REGLK_POS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_lock,
  input  logic              rd_own,
  input  logic              wr_lock,
  input  logic              wr_own,
  input  logic [DATA_W-1:0] wdata,
  output logic              id_q,
  output logic              rl_q,
  output logic              rl_take,
  output logic              own_wr_ok
);
  logic id_d;
  logic rl_d;

  // register lock is only reachable from inside the inter-driver lock
  assign rl_take   = rd_own && id_q && !rl_q;
  assign own_wr_ok = wr_own && id_q && rl_q;

  always_comb begin
    id_d = id_q;
    if (rd_lock && !id_q)
      id_d = 1'b1;
    else if (wr_lock && !wdata[0])
      id_d = 1'b0;
  end

  always_comb begin
    rl_d = rl_q;
    if (rl_take)
      rl_d = 1'b1;
    else if (own_wr_ok && !wdata[REGLK_POS])
      rl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= 1'b0;
      rl_q <= 1'b0;
    end else begin
      id_q <= id_d;
      rl_q <= rl_d;
    end
  end
endmodule

// File: rtl/srs_fw_arbiter.sv
module srs_fw_arbiter #(
  parameter int NUM_RES = 5,
  parameter int NVM_IDX = 3
) (
  input  logic               fw_valid,
  input  logic               fw_op,
  input  logic [NUM_RES-1:0] fw_mask,
  input  logic [NUM_RES-1:0] sw_own,
  input  logic [NUM_RES-1:0] fw_own,
  input  logic               flash_busy,
  input  logic               rl_held,
  input  logic               rl_take,
  output logic               grant,
  output logic [NUM_RES-1:0] fw_set,
  output logic [NUM_RES-1:0] fw_clr
);
  import srs_pkg::*;

  logic [NUM_RES-1:0] hit;
  logic               is_claim;
  logic               blocked;

  // per-resource collision: either agent already owns it, or NVM meets a busy flash engine
  for (genvar g = 0; g < NUM_RES; g++) begin : g_hit
    if (g == NVM_IDX) begin : g_nvm
      assign hit[g] = fw_mask[g] && (sw_own[g] || fw_own[g] || flash_busy);
    end else begin : g_plain
      assign hit[g] = fw_mask[g] && (sw_own[g] || fw_own[g]);
    end
  end

  assign is_claim = (fw_op == FW_CLAIM);
  assign blocked  = (|hit) || rl_held || rl_take;

  always_comb begin
    grant  = 1'b0;
    fw_set = '0;
    fw_clr = '0;
    if (fw_valid) begin
      if (is_claim) begin
        grant = !blocked;
        if (!blocked)
          fw_set = fw_mask;
      end else begin
        grant  = 1'b1;
        fw_clr = fw_mask;
      end
    end
  end
endmodule

// File: rtl/srs_own_table.sv
module srs_own_table #(
  parameter int NUM_RES = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_wr,
  input  logic [NUM_RES-1:0] sw_wval,
  input  logic [NUM_RES-1:0] fw_set,
  input  logic [NUM_RES-1:0] fw_clr,
  output logic [NUM_RES-1:0] sw_q,
  output logic [NUM_RES-1:0] fw_q
);
  for (genvar g = 0; g < NUM_RES; g++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sw_q[g] <= 1'b0;
        fw_q[g] <= 1'b0;
      end else begin
        if (sw_wr)
          sw_q[g] <= sw_wval[g];
        if (fw_set[g])
          fw_q[g] <= 1'b1;
        else if (fw_clr[g])
          fw_q[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/resource_semaphore.sv
module resource_semaphore #(
  parameter int NUM_RES   = 5,
  parameter int FW_SHIFT  = 5,
  parameter int NVM_IDX   = 3,
  parameter int DATA_W    = 32,
  parameter int REGLK_POS = 31,
  parameter int BUSY_POS  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_rd_en,
  input  logic               sw_wr_en,
  input  logic               sw_addr,
  input  logic [DATA_W-1:0]  sw_wdata,
  output logic [DATA_W-1:0]  sw_rdata,
  input  logic               fw_valid,
  input  logic               fw_op,
  input  logic [NUM_RES-1:0] fw_mask,
  output logic               fw_done,
  output logic               fw_granted,
  input  logic               flash_busy
);
  import srs_pkg::*;

  localparam int FW_TOP = FW_SHIFT + NUM_RES - 1;

  logic               rd_lock, rd_own, wr_lock, wr_own;
  logic               id_q, rl_q, rl_take, own_wr_ok;
  logic [NUM_RES-1:0] sw_q, fw_q, fw_set, fw_clr;
  logic               grant;

  assign rd_lock = sw_rd_en && (sw_addr == ADDR_LOCK);
  assign rd_own  = sw_rd_en && (sw_addr == ADDR_OWN);
  assign wr_lock = sw_wr_en && (sw_addr == ADDR_LOCK);
  assign wr_own  = sw_wr_en && (sw_addr == ADDR_OWN);

  srs_lock_unit #(.DATA_W(DATA_W), .REGLK_POS(REGLK_POS)) u_lock (
    .clk(clk), .rst_n(rst_n),
    .rd_lock(rd_lock), .rd_own(rd_own), .wr_lock(wr_lock), .wr_own(wr_own),
    .wdata(sw_wdata),
    .id_q(id_q), .rl_q(rl_q), .rl_take(rl_take), .own_wr_ok(own_wr_ok)
  );

  srs_fw_arbiter #(.NUM_RES(NUM_RES), .NVM_IDX(NVM_IDX)) u_arb (
    .fw_valid(fw_valid), .fw_op(fw_op), .fw_mask(fw_mask),
    .sw_own(sw_q), .fw_own(fw_q), .flash_busy(flash_busy),
    .rl_held(rl_q), .rl_take(rl_take),
    .grant(grant), .fw_set(fw_set), .fw_clr(fw_clr)
  );

  srs_own_table #(.NUM_RES(NUM_RES)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .sw_wr(own_wr_ok), .sw_wval(sw_wdata[NUM_RES-1:0]),
    .fw_set(fw_set), .fw_clr(fw_clr),
    .sw_q(sw_q), .fw_q(fw_q)
  );

  always_comb begin
    sw_rdata = '0;
    if (sw_addr == ADDR_LOCK) begin
      sw_rdata[0] = id_q;
    end else begin
      sw_rdata[NUM_RES-1:0]     = sw_q;
      sw_rdata[FW_TOP:FW_SHIFT] = fw_q;
      sw_rdata[BUSY_POS]        = flash_busy;
      sw_rdata[REGLK_POS]       = rl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fw_done    <= 1'b0;
      fw_granted <= 1'b0;
    end else begin
      fw_done    <= fw_valid;
      fw_granted <= grant;
    end
  end
endmodule

// File: rtl/resource_semaphore_chk.sv
module resource_semaphore_chk #(
  parameter int NUM_RES = 5,
  parameter int NVM_IDX = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sw_rd_en,
  input logic               sw_wr_en,
  input logic               sw_addr,
  input logic               fw_valid,
  input logic               fw_op,
  input logic [NUM_RES-1:0] fw_mask,
  input logic               fw_done,
  input logic               fw_granted,
  input logic               flash_busy,
  input logic               id_q,
  input logic               rl_q,
  input logic [NUM_RES-1:0] sw_q,
  input logic [NUM_RES-1:0] fw_q
);
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    fw_valid |=> fw_done); // R11
  AST_NO_DONE_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !fw_valid |=> !fw_done); // R11
  AST_NVM_BUSY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_valid && !fw_op && fw_mask[NVM_IDX] && flash_busy) |=> !fw_granted); // R8
  AST_CLAIM_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_valid && !fw_op && ((fw_mask & (sw_q | fw_q)) != '0)) |=> !fw_granted); // R7
  AST_RELEASE_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_valid && fw_op) |=> fw_granted); // R9
  AST_SW_FIELD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_wr_en && sw_addr && id_q && rl_q) |=> $stable(sw_q)); // R4
  AST_READ_BEATS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd_en && sw_addr && id_q && !rl_q && fw_valid && !fw_op) |=> (rl_q && !fw_granted)); // R10
  AST_LOCK_READ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd_en && !sw_addr) |=> id_q); // R2
endmodule

bind resource_semaphore resource_semaphore_chk #(.NUM_RES(NUM_RES), .NVM_IDX(NVM_IDX)) chk_i (
  .clk(clk), .rst_n(rst_n), .sw_rd_en(sw_rd_en), .sw_wr_en(sw_wr_en), .sw_addr(sw_addr),
  .fw_valid(fw_valid), .fw_op(fw_op), .fw_mask(fw_mask), .fw_done(fw_done),
  .fw_granted(fw_granted), .flash_busy(flash_busy),
  .id_q(id_q), .rl_q(rl_q), .sw_q(sw_q), .fw_q(fw_q)
);

// File: tb/resource_semaphore_tb_top.sv
module resource_semaphore_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_rd_en = 1'b0, sw_wr_en = 1'b0, sw_addr = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic        fw_valid = 1'b0, fw_op = 1'b0;
  logic [4:0]  fw_mask = '0;
  logic        fw_done, fw_granted;
  logic        flash_busy = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  resource_semaphore dut_i (
    .clk(clk), .rst_n(rst_n), .sw_rd_en(sw_rd_en), .sw_wr_en(sw_wr_en), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .fw_valid(fw_valid), .fw_op(fw_op),
    .fw_mask(fw_mask), .fw_done(fw_done), .fw_granted(fw_granted), .flash_busy(flash_busy)
  );

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic        addr;
    logic [31:0] wd;
    logic        fv;
    logic        fop;
    logic [4:0]  fm;
    logic        busy;
    logic        chk;
    logic [31:0] exp;
    logic        egr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b1,32'h0,1'b0,8'd1},          // R1 idle image
    '{1'b0,1'b0,1'b0,32'h0,1'b1,1'b0,5'b00001,1'b0,1'b0,32'h0,1'b1,8'd7},          // R7 claim CSR
    '{1'b1,1'b0,1'b0,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b1,32'h0,1'b0,8'd2},          // R2 read gets 0
    '{1'b1,1'b0,1'b0,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b1,32'h1,1'b0,8'd2},          // R2 read sees held
    '{1'b1,1'b0,1'b1,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b1,32'h20,1'b0,8'd3},         // R3 take reg lock
    '{1'b1,1'b0,1'b1,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b1,32'h80000020,1'b0,8'd3},   // R3 lock held
    '{1'b0,1'b0,1'b0,32'h0,1'b1,1'b0,5'b00010,1'b0,1'b0,32'h0,1'b0,8'd7},          // R7 refused: lock held
    '{1'b0,1'b1,1'b1,32'h80000009,1'b0,1'b0,5'b00000,1'b0,1'b0,32'h0,1'b0,8'd5},   // R5 forced write
    '{1'b0,1'b0,1'b1,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b1,32'h80000029,1'b0,8'd5},   // R5 image
    '{1'b0,1'b1,1'b1,32'h9,1'b0,1'b0,5'b00000,1'b0,1'b0,32'h0,1'b0,8'd6},          // R6 drop reg lock
    '{1'b0,1'b1,1'b0,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b0,32'h0,1'b0,8'd2},          // R2 drop lock
    '{1'b0,1'b0,1'b0,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b1,32'h0,1'b0,8'd2},          // R2 lock free
    '{1'b0,1'b0,1'b1,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b1,32'h29,1'b0,8'd6},         // R6 reg lock free
    '{1'b0,1'b1,1'b1,32'h80000000,1'b0,1'b0,5'b00000,1'b0,1'b0,32'h0,1'b0,8'd4},   // R4 unlocked write
    '{1'b0,1'b0,1'b1,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b1,32'h29,1'b0,8'd4},         // R4 unchanged
    '{1'b0,1'b0,1'b0,32'h0,1'b1,1'b0,5'b00100,1'b1,1'b0,32'h0,1'b1,8'd8},          // R8 busy irrelevant
    '{1'b0,1'b0,1'b0,32'h0,1'b1,1'b0,5'b01000,1'b0,1'b0,32'h0,1'b0,8'd7},          // R7 sw holds NVM
    '{1'b0,1'b0,1'b0,32'h0,1'b1,1'b1,5'b00001,1'b0,1'b0,32'h0,1'b1,8'd9},          // R9 release CSR
    '{1'b0,1'b0,1'b1,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b1,32'h89,1'b0,8'd9},         // R9 sw kept
    '{1'b0,1'b0,1'b1,32'h0,1'b0,1'b0,5'b00000,1'b1,1'b1,32'h489,1'b0,8'd8},        // R8 busy visible
    '{1'b1,1'b0,1'b0,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b1,32'h0,1'b0,8'd2},          // R2
    '{1'b1,1'b0,1'b1,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b1,32'h89,1'b0,8'd3},         // R3
    '{1'b0,1'b1,1'b1,32'h80000000,1'b0,1'b0,5'b00000,1'b0,1'b0,32'h0,1'b0,8'd5},   // R5 clear sw
    '{1'b0,1'b1,1'b1,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b0,32'h0,1'b0,8'd6},          // R6
    '{1'b0,1'b0,1'b0,32'h0,1'b1,1'b0,5'b01000,1'b1,1'b0,32'h0,1'b0,8'd8},          // R8 NVM busy refused
    '{1'b0,1'b0,1'b0,32'h0,1'b1,1'b0,5'b01000,1'b0,1'b0,32'h0,1'b1,8'd7},          // R7 NVM granted
    '{1'b0,1'b0,1'b1,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b1,32'h180,1'b0,8'd7},        // R7 fw bits 9:5
    '{1'b1,1'b0,1'b1,32'h0,1'b1,1'b0,5'b00010,1'b0,1'b1,32'h180,1'b0,8'd10},       // R10 same cycle
    '{1'b0,1'b0,1'b1,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b1,32'h80000180,1'b0,8'd10},  // R10 read won
    '{1'b0,1'b0,1'b0,32'h0,1'b1,1'b1,5'b11111,1'b0,1'b0,32'h0,1'b1,8'd9},          // R9 release all
    '{1'b0,1'b1,1'b1,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b0,32'h0,1'b0,8'd6},          // R6
    '{1'b0,1'b1,1'b0,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b0,32'h0,1'b0,8'd2},          // R2
    '{1'b0,1'b0,1'b1,32'h0,1'b0,1'b0,5'b00000,1'b0,1'b1,32'h0,1'b0,8'd9}           // R9 all clear
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sw_rd_en = 1'b0; sw_wr_en = 1'b0; sw_addr = 1'b0; sw_wdata = '0;
    fw_valid = 1'b0; fw_op = 1'b0; fw_mask = '0; flash_busy = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    sw_addr = 1'b0; #1 check("R1 lock reg", sw_rdata, 32'h0);
    sw_addr = 1'b1; #1 check("R1 own reg", sw_rdata, 32'h0);
    check("R1 done", {31'b0, fw_done}, 32'h0);
    check("R1 granted", {31'b0, fw_granted}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sw_rd_en = VECS[i].rd; sw_wr_en = VECS[i].wr; sw_addr = VECS[i].addr;
      sw_wdata = VECS[i].wd; fw_valid = VECS[i].fv; fw_op = VECS[i].fop;
      fw_mask = VECS[i].fm; flash_busy = VECS[i].busy;
      #5;
      if (VECS[i].chk)
        check($sformatf("R%0d rdata step %0d", VECS[i].req, i), sw_rdata, VECS[i].exp);
      @(posedge clk);
      #2;
      check($sformatf("R11 done step %0d", i), {31'b0, fw_done}, {31'b0, VECS[i].fv});
      if (VECS[i].fv)
        check($sformatf("R%0d grant step %0d", VECS[i].req, i), {31'b0, fw_granted}, {31'b0, VECS[i].egr});
      idle();
    end

    // R11 done drops after the request cycle
    @(posedge clk); #2;
    check("R11 done low", {31'b0, fw_done}, 32'h0);

    // R1 reset mid-run clears locks and ownership
    @(negedge clk);
    sw_rd_en = 1'b1; sw_addr = 1'b0;
    fw_valid = 1'b1; fw_mask = 5'b00001;
    @(negedge clk);
    idle();
    sw_addr = 1'b0; #1 check("R1 lock set before reset", sw_rdata, 32'h1);
    sw_addr = 1'b1; #1 check("R1 fw set before reset", sw_rdata, 32'h20);
    rst_n = 1'b0;
    #3;
    sw_addr = 1'b0; #1 check("R1 lock after reset", sw_rdata, 32'h0);
    sw_addr = 1'b1; #1 check("R1 own after reset", sw_rdata, 32'h0);
    check("R1 done after reset", {31'b0, fw_done}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule